// File: doc/BRIEF.md
# Scintillator Trigger Handshake Controller

The block turns discriminated hits from four beam scintillators into triggers for a device under test (DUT). A programmable mask picks which scintillators take part in a coincidence. A trigger is a new coincidence: every enabled input is high in a cycle in which the combined condition was not met in the cycle before. A particle that keeps its inputs high for several cycles therefore gives only one trigger. Each accepted trigger records a timestamp and an event number in a small readout FIFO. The timestamp is a free-running count of system clock cycles.

The DUT link has a trigger output, a busy input and a clock line. The clock line is split at the port into an input (`dut_clk_i`) and an output (`dut_clk_o`). The external line driver combines them. Three link modes are available:
- a plain one-cycle trigger pulse;
- a trigger held until the DUT answers with busy;
- the busy handshake followed by the event number sent serially on the trigger line, one bit per pulse on the clock line.

While the controller is idle, the DUT can hold its clock line high to refuse triggers. Coincidences that arrive during this veto are discarded.

Top module: `trig_hs_ctrl`

## Requirements
- R1: After a synchronous reset, `dut_trig_o` and `dut_clk_o` are low, the FIFO is empty (`rd_valid` low), `lost_cnt` is 0 and `tmo_flag` is 0.
- R2: A coincidence needs every input enabled in `cfg_mask` to be high in the same cycle. Inputs that are not enabled have no effect. A mask of zero never triggers.
- R3: A coincidence held high over many cycles gives exactly one trigger. A new trigger needs the condition to fall and rise again.
- R4: In mode 2'b00, an accepted coincidence drives `dut_trig_o` high for exactly one cycle, in the cycle after the coincidence is presented. `dut_busy_i` has no effect in this mode.
- R5: In mode 2'b01, `dut_trig_o` rises in the cycle after the coincidence. It stays high until the first clock edge that samples `dut_busy_i` high, and is low from the next cycle on. No coincidence is accepted until busy is low again at a clock edge.
- R6: In modes 2'b10 and 2'b11, the block sends the 16-bit event number once busy is seen. It makes 16 pulses on `dut_clk_o`, each high for `cfg_half` cycles and low for `cfg_half` cycles. The bit is placed on `dut_trig_o` least significant bit first, and each bit is valid from the rising edge of its pulse. Afterwards both lines stay low until busy falls.
- R7: While the controller is idle and `dut_clk_i` is high, a coincidence is discarded. It makes no trigger, no FIFO entry and no event number increment.
- R8: The FIFO timestamp equals the number of clock edges since reset was released, taken when the accepted coincidence is presented. Entries therefore differ by the cycles between their coincidences.
- R9: Event numbers start at 0 after reset and increase by one for each accepted trigger only.
- R10: The FIFO holds 16 entries. A coincidence that arrives while the FIFO is full makes no trigger and increments `lost_cnt`.
- R11: In modes 2'b01 and above, `dut_trig_o` stays high for `cfg_tmo`+1 cycles at most if busy never comes. It then returns low and `tmo_flag` is set. The flag stays set until reset.
- R12: `rd_valid` shows a non-empty FIFO. `rd_ts` and `rd_evt` show the oldest entry, and `rd_en` with `rd_valid` removes it. Entries leave in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the timestamp time base |
| rst | input | 1 | Synchronous active-high reset |
| hit_i | input | 4 | Synchronous scintillator hit levels |
| cfg_mask | input | 4 | Coincidence enable per input |
| cfg_mode | input | 2 | Link mode: 00 pulse, 01 busy handshake, 1x handshake with serial number |
| cfg_half | input | 8 | Cycles per half period of the serial clock (0 treated as 1) |
| cfg_tmo | input | 8 | Busy wait limit in cycles, minus one |
| dut_trig_o | output | 1 | Trigger to the DUT; carries the serial bits in the data phase |
| dut_busy_i | input | 1 | Busy answer from the DUT |
| dut_clk_i | input | 1 | DUT side of the clock line; high vetoes triggers while idle |
| dut_clk_o | output | 1 | Serial bit clock driven toward the DUT |
| rd_en | input | 1 | Remove the oldest FIFO entry |
| rd_valid | output | 1 | FIFO not empty |
| rd_ts | output | 48 | Timestamp of the oldest entry |
| rd_evt | output | 16 | Event number of the oldest entry |
| lost_cnt | output | 16 | Coincidences refused because the FIFO was full |
| tmo_flag | output | 1 | Sticky busy-timeout indication |

## Verification
The checks assume that `cfg_mode` changes only while the controller is idle and no trigger is on the line. This matters because the pulse-width, busy and serial-clock properties read the current mode. The stimulus therefore sets the mode at the start of each scenario and waits for every handshake to complete before changing it. The checks also assume that the DUT holds `dut_clk_i` low during the serial phase. The bench drives the veto only around idle coincidences.

// File: rtl/trig_hs_pkg.sv
package trig_hs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_WAIT_BUSY = 2'd1,
        ST_SHIFT     = 2'd2,
        ST_WAIT_REL  = 2'd3
    } hs_state_e;

    localparam logic [1:0] LINK_PULSE = 2'b00;
    localparam logic [1:0] LINK_BUSY  = 2'b01;

endpackage

// File: rtl/trig_coinc.sv
module trig_coinc #(
    parameter int N_IN = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [N_IN-1:0] hit,
    input  logic [N_IN-1:0] mask,
    output logic            cand
);

    logic level;
    logic level_d;
    logic level_q;

    always_comb begin
        level   = (&(hit | ~mask)) && (|mask);
        cand    = level && !level_q;
        level_d = rst ? 1'b0 : level;
    end

    always_ff @(posedge clk) begin
        level_q <= level_d;
    end

endmodule

// File: rtl/trig_fifo.sv
module trig_fifo #(
    parameter int DW    = 64,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [DW-1:0] wdata,
    input  logic          pop,
    output logic [DW-1:0] rdata,
    output logic          empty,
    output logic          full,
    output logic [CW-1:0] count
);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } fifo_ptr_t;

    fifo_ptr_t     p_d;
    fifo_ptr_t     p_q;
    logic [DW-1:0] mem [DEPTH];
    logic          do_push;
    logic          do_pop;

    always_comb begin
        empty   = (p_q.cnt == '0);
        full    = (p_q.cnt == CW'(DEPTH));
        do_push = push && !full;
        do_pop  = pop && !empty;
        p_d     = p_q;
        if (do_push) p_d.wp = p_q.wp + 1'b1;
        if (do_pop)  p_d.rp = p_q.rp + 1'b1;
        case ({do_push, do_pop})
            2'b10:   p_d.cnt = p_q.cnt + 1'b1;
            2'b01:   p_d.cnt = p_q.cnt - 1'b1;
            default: p_d.cnt = p_q.cnt;
        endcase
        if (rst) p_d = '0;
        rdata = mem[p_q.rp];
        count = p_q.cnt;
    end

    always_ff @(posedge clk) begin
        p_q <= p_d;
        if (do_push) mem[p_q.wp] <= wdata;
    end

endmodule

// File: rtl/trig_hs_ctrl.sv
module trig_hs_ctrl
    import trig_hs_pkg::*;
#(
    parameter int N_IN   = 4,
    parameter int TS_W   = 48,
    parameter int EV_W   = 16,
    parameter int DEPTH  = 16,
    parameter int TMO_W  = 8,
    parameter int HALF_W = 8,
    parameter int LOST_W = 16,
    localparam int DW    = TS_W + EV_W,
    localparam int BIT_W = $clog2(EV_W),
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_IN-1:0]   hit_i,
    input  logic [N_IN-1:0]   cfg_mask,
    input  logic [1:0]        cfg_mode,
    input  logic [HALF_W-1:0] cfg_half,
    input  logic [TMO_W-1:0]  cfg_tmo,
    output logic              dut_trig_o,
    input  logic              dut_busy_i,
    input  logic              dut_clk_i,
    output logic              dut_clk_o,
    input  logic              rd_en,
    output logic              rd_valid,
    output logic [TS_W-1:0]   rd_ts,
    output logic [EV_W-1:0]   rd_evt,
    output logic [LOST_W-1:0] lost_cnt,
    output logic              tmo_flag
);

    typedef struct packed {
        hs_state_e         state;
        logic              trig;
        logic              clko;
        logic [TS_W-1:0]   ts;
        logic [EV_W-1:0]   evt;
        logic [EV_W-1:0]   sh;
        logic [TMO_W-1:0]  tmo;
        logic [HALF_W-1:0] hc;
        logic              ph;
        logic [BIT_W-1:0]  bi;
        logic [LOST_W-1:0] lost;
        logic              flag;
    } ctl_t;

    ctl_t          c_d;
    ctl_t          c_q;
    logic          cand;
    logic          push;
    logic          fifo_empty;
    logic          fifo_full;
    logic [CW-1:0] fifo_cnt;
    logic [DW-1:0] fifo_rdata;
    logic [EV_W-1:0] evt_now;
    logic          hs_on;
    logic          half_last;

    trig_coinc #(.N_IN(N_IN)) u_coinc (
        .clk  (clk),
        .rst  (rst),
        .hit  (hit_i),
        .mask (cfg_mask),
        .cand (cand)
    );

    trig_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .push  (push),
        .wdata ({c_q.ts, c_q.evt}),
        .pop   (rd_en),
        .rdata (fifo_rdata),
        .empty (fifo_empty),
        .full  (fifo_full),
        .count (fifo_cnt)
    );

    always_comb begin
        c_d       = c_q;
        push      = 1'b0;
        hs_on     = (cfg_mode != LINK_PULSE);
        half_last = (cfg_half == '0) || (c_q.hc == cfg_half - HALF_W'(1));
        c_d.ts    = c_q.ts + 1'b1;

        if (cand && fifo_full) c_d.lost = c_q.lost + 1'b1;

        case (c_q.state)
            ST_IDLE: begin
                c_d.trig = 1'b0;
                c_d.clko = 1'b0;
                if (cand && !fifo_full && !dut_clk_i && !(hs_on && dut_busy_i)) begin
                    push     = 1'b1;
                    c_d.evt  = c_q.evt + 1'b1;
                    c_d.sh   = c_q.evt;
                    c_d.trig = 1'b1;
                    c_d.tmo  = '0;
                    if (hs_on) c_d.state = ST_WAIT_BUSY;
                end
            end
            ST_WAIT_BUSY: begin
                if (dut_busy_i) begin
                    if (cfg_mode != LINK_BUSY) begin
                        c_d.state = ST_SHIFT;
                        c_d.trig  = c_q.sh[0];
                        c_d.clko  = 1'b1;
                        c_d.hc    = '0;
                        c_d.ph    = 1'b0;
                        c_d.bi    = '0;
                    end else begin
                        c_d.state = ST_WAIT_REL;
                        c_d.trig  = 1'b0;
                    end
                end else if (c_q.tmo == cfg_tmo) begin
                    c_d.state = ST_IDLE;
                    c_d.trig  = 1'b0;
                    c_d.flag  = 1'b1;
                end else begin
                    c_d.tmo = c_q.tmo + 1'b1;
                end
            end
            ST_SHIFT: begin
                if (!half_last) begin
                    c_d.hc = c_q.hc + 1'b1;
                end else begin
                    c_d.hc = '0;
                    if (!c_q.ph) begin
                        c_d.ph   = 1'b1;
                        c_d.clko = 1'b0;
                    end else if (c_q.bi == BIT_W'(EV_W - 1)) begin
                        c_d.state = ST_WAIT_REL;
                        c_d.trig  = 1'b0;
                        c_d.clko  = 1'b0;
                    end else begin
                        c_d.bi   = c_q.bi + 1'b1;
                        c_d.sh   = c_q.sh >> 1;
                        c_d.trig = c_q.sh[1];
                        c_d.clko = 1'b1;
                        c_d.ph   = 1'b0;
                    end
                end
            end
            default: begin
                c_d.trig = 1'b0;
                c_d.clko = 1'b0;
                if (!dut_busy_i) c_d.state = ST_IDLE;
            end
        endcase

        if (rst) c_d = '0;
    end

    always_ff @(posedge clk) begin
        c_q <= c_d;
    end

    assign dut_trig_o = c_q.trig;
    assign dut_clk_o  = c_q.clko;
    assign rd_valid   = !fifo_empty;
    assign rd_ts      = fifo_rdata[DW-1:EV_W];
    assign rd_evt     = fifo_rdata[EV_W-1:0];
    assign lost_cnt   = c_q.lost;
    assign tmo_flag   = c_q.flag;
    assign evt_now    = c_q.evt;

endmodule

// File: rtl/trig_hs_ctrl_chk.sv
module trig_hs_ctrl_chk #(
    parameter int EV_W   = 16,
    parameter int LOST_W = 16,
    parameter int DEPTH  = 16,
    parameter int CW     = 5
) (
    input logic              clk,
    input logic              rst,
    input logic [1:0]        cfg_mode,
    input logic              dut_trig_o,
    input logic              dut_clk_o,
    input logic              dut_busy_i,
    input logic              tmo_flag,
    input logic [LOST_W-1:0] lost_cnt,
    input logic              fifo_full,
    input logic [CW-1:0]     fifo_cnt,
    input logic              push,
    input logic [EV_W-1:0]   evt_now
);

    // R4: pulse mode trigger lasts one cycle
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
        (cfg_mode == 2'b00 && dut_trig_o) |=> !dut_trig_o);

    // R5: a busy answer removes the trigger in busy mode
    a_r5_busy_drops_trig: assert property (@(posedge clk) disable iff (rst)
        (cfg_mode == 2'b01 && dut_busy_i) |=> !dut_trig_o);

    // R6: serial clock only in the data mode
    a_r6_clk_data_only: assert property (@(posedge clk) disable iff (rst)
        dut_clk_o |-> cfg_mode[1]);

    // R9: event number moves by one and only with a push
    a_r9_evt_step: assert property (@(posedge clk) disable iff (rst)
        (evt_now != $past(evt_now)) |-> (evt_now == EV_W'($past(evt_now) + 1'b1) && $past(push)));

    // R10: lost count moves only while full
    a_r10_lost_on_full: assert property (@(posedge clk) disable iff (rst)
        (lost_cnt != $past(lost_cnt)) |-> $past(fifo_full));

    // R10: nothing is written into a full FIFO
    a_r10_no_push_full: assert property (@(posedge clk) disable iff (rst)
        push |-> !fifo_full);

    // R11: the timeout flag holds
    a_r11_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        tmo_flag |=> tmo_flag);

    // R12: occupancy never above the depth
    a_r12_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        fifo_cnt <= CW'(DEPTH));

endmodule

bind trig_hs_ctrl trig_hs_ctrl_chk #(
    .EV_W(EV_W), .LOST_W(LOST_W), .DEPTH(DEPTH), .CW(CW)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cfg_mode   (cfg_mode),
    .dut_trig_o (dut_trig_o),
    .dut_clk_o  (dut_clk_o),
    .dut_busy_i (dut_busy_i),
    .tmo_flag   (tmo_flag),
    .lost_cnt   (lost_cnt),
    .fifo_full  (fifo_full),
    .fifo_cnt   (fifo_cnt),
    .push       (push),
    .evt_now    (evt_now)
);

// File: tb/trig_hs_ctrl_bench.sv
module trig_hs_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  hit_i = '0;
    logic [3:0]  cfg_mask = 4'b0011;
    logic [1:0]  cfg_mode = 2'b00;
    logic [7:0]  cfg_half = 8'd3;
    logic [7:0]  cfg_tmo = 8'd50;
    logic        dut_trig_o;
    logic        dut_busy_i = 1'b0;
    logic        dut_clk_i = 1'b0;
    logic        dut_clk_o;
    logic        rd_en = 1'b0;
    logic        rd_valid;
    logic [47:0] rd_ts;
    logic [15:0] rd_evt;
    logic [15:0] lost_cnt;
    logic        tmo_flag;

    int          errs = 0;
    int          checks = 0;
    longint      cyc = 0;
    logic [47:0] q_ts[$];
    logic [15:0] q_ev[$];
    logic [15:0] nxt_ev = '0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    trig_hs_ctrl u_trig_hs_ctrl (
        .clk(clk), .rst(rst), .hit_i(hit_i), .cfg_mask(cfg_mask),
        .cfg_mode(cfg_mode), .cfg_half(cfg_half), .cfg_tmo(cfg_tmo),
        .dut_trig_o(dut_trig_o), .dut_busy_i(dut_busy_i),
        .dut_clk_i(dut_clk_i), .dut_clk_o(dut_clk_o), .rd_en(rd_en),
        .rd_valid(rd_valid), .rd_ts(rd_ts), .rd_evt(rd_evt),
        .lost_cnt(lost_cnt), .tmo_flag(tmo_flag)
    );

    task automatic chk(string req, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; hit_i = '0; dut_busy_i = 1'b0; dut_clk_i = 1'b0; rd_en = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        q_ts.delete(); q_ev.delete(); nxt_ev = '0;
    endtask

    task automatic coinc(logic [3:0] pat, bit acc, string req);
        @(negedge clk);
        hit_i = pat;
        if (acc) begin
            q_ts.push_back(cyc[47:0]);
            q_ev.push_back(nxt_ev);
            nxt_ev++;
        end
        @(negedge clk);
        hit_i = '0;
        chk(req, "trigger after coincidence", dut_trig_o, acc);
    endtask

    task automatic drain(string req);
        @(negedge clk);
        while (q_ts.size() > 0) begin
            logic [47:0] ets;
            logic [15:0] eev;
            ets = q_ts.pop_front();
            eev = q_ev.pop_front();
            chk(req, "rd_valid with entries", rd_valid, 1);
            chk("R8", "timestamp", rd_ts, ets);
            chk("R9", "event number", rd_evt, eev);
            rd_en = 1'b1;
            @(negedge clk);
            rd_en = 1'b0;
        end
        chk("R12", "FIFO empty after drain", rd_valid, 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1", "trig after reset", dut_trig_o, 0);
        chk("R1", "clk_o after reset", dut_clk_o, 0);
        chk("R1", "rd_valid after reset", rd_valid, 0);
        chk("R1", "lost after reset", lost_cnt, 0);
        chk("R1", "flag after reset", tmo_flag, 0);
    endtask

    task automatic t_nohs();
        cfg_mode = 2'b00; cfg_mask = 4'b0011;
        coinc(4'b0011, 1, "R4");
        @(negedge clk);
        chk("R4", "pulse is one cycle", dut_trig_o, 0);
        @(negedge clk);
        hit_i = 4'b1011;
        q_ts.push_back(cyc[47:0]); q_ev.push_back(nxt_ev); nxt_ev++;
        @(negedge clk);
        chk("R3", "held coincidence first trigger", dut_trig_o, 1);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R3", "held coincidence no retrigger", dut_trig_o, 0);
        end
        hit_i = '0;
        coinc(4'b0001, 0, "R2");
        coinc(4'b1100, 0, "R2");
        dut_busy_i = 1'b1;
        coinc(4'b0011, 1, "R4");
        @(negedge clk);
        chk("R4", "busy ignored, pulse ends", dut_trig_o, 0);
        dut_busy_i = 1'b0;
        cfg_mask = 4'b0000;
        coinc(4'b1111, 0, "R2");
        cfg_mask = 4'b0011;
    endtask

    task automatic t_veto();
        cfg_mode = 2'b00;
        dut_clk_i = 1'b1;
        coinc(4'b0011, 0, "R7");
        dut_clk_i = 1'b0;
        coinc(4'b0011, 1, "R7");
        drain("R7");
    endtask

    task automatic t_busy();
        cfg_mode = 2'b01; cfg_tmo = 8'd50;
        coinc(4'b0011, 1, "R5");
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R5", "trigger held awaiting busy", dut_trig_o, 1);
        end
        dut_busy_i = 1'b1;
        @(negedge clk);
        chk("R5", "trigger drops after busy", dut_trig_o, 0);
        coinc(4'b0011, 0, "R5");
        dut_busy_i = 1'b0;
        @(negedge clk);
        coinc(4'b0011, 1, "R5");
        dut_busy_i = 1'b1;
        @(negedge clk);
        dut_busy_i = 1'b0;
        repeat (2) @(negedge clk);
        drain("R9");
    endtask

    task automatic t_timeout();
        cfg_mode = 2'b01; cfg_tmo = 8'd5;
        chk("R11", "flag clear before timeout", tmo_flag, 0);
        coinc(4'b0011, 1, "R11");
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk("R11", "trigger high within limit", dut_trig_o, 1);
        end
        @(negedge clk);
        chk("R11", "trigger low after timeout", dut_trig_o, 0);
        chk("R11", "flag set after timeout", tmo_flag, 1);
        cfg_tmo = 8'd50;
        drain("R11");
    endtask

    task automatic t_data();
        logic [15:0] exp_ev;
        logic [15:0] got;
        int          rises;
        int          hi;
        int          first_r;
        int          last_f;
        logic        prev;
        cfg_mode = 2'b10; cfg_half = 8'd3; cfg_tmo = 8'd50;
        nxt_ev = nxt_ev;
        exp_ev = nxt_ev;
        coinc(4'b0011, 1, "R6");
        dut_busy_i = 1'b1;
        got = '0; rises = 0; hi = 0; first_r = -1; last_f = -1; prev = 1'b0;
        for (int i = 0; i < 130; i++) begin
            @(negedge clk);
            if (dut_clk_o) begin
                hi++;
                if (!prev) begin
                    if (rises < 16) got[rises] = dut_trig_o;
                    if (first_r < 0) first_r = i;
                    rises++;
                end
            end else if (prev) begin
                last_f = i;
            end
            prev = dut_clk_o;
        end
        chk("R6", "serial pulse count", rises, 16);
        chk("R6", "serial high cycles", hi, 48);
        chk("R6", "first rise to last fall span", last_f - first_r, 93);
        chk("R6", "serial event number", got, exp_ev);
        chk("R6", "trig low after serial", dut_trig_o, 0);
        chk("R6", "clk low after serial", dut_clk_o, 0);
        dut_busy_i = 1'b0;
        repeat (2) @(negedge clk);
        drain("R6");
    endtask

    task automatic t_full();
        cfg_mode = 2'b00;
        for (int i = 0; i < 16; i++) coinc(4'b0011, 1, "R10");
        chk("R10", "lost before overflow", lost_cnt, 0);
        coinc(4'b0011, 0, "R10");
        chk("R10", "lost after refused coincidence", lost_cnt, 1);
        drain("R10");
        coinc(4'b0011, 1, "R10");
        drain("R12");
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    endtask

    initial begin
        do_reset();
        t_reset();
        t_nohs();
        t_veto();
        t_busy();
        t_timeout();
        t_data();
        t_full();
        chk("R11", "flag still set later", tmo_flag, 1);
        do_reset();
        @(negedge clk);
        chk("R1", "flag cleared by reset", tmo_flag, 0);
        chk("R1", "lost cleared by reset", lost_cnt, 0);
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errs++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

endmodule